// File: doc/BRIEF.md
# One-Shot Bus-Clock Timer with Reset Detection

This block is a 16-bit one-shot down-counter that software arms through two byte-wide registers. The counter counts rising edges of the CPU bus clock (M2). When it steps from one to zero it raises a flag and an interrupt line and then halts. Loading the high byte only stages a value. Loading the low byte arms the timer whenever the combined count is nonzero. Bytes written while the timer runs replace that byte of the live count.

All logic runs on a free-running reference clock. M2 is brought in through a synchronizer, and its rising edges are used as count ticks. A watchdog in the reference-clock domain measures how long M2 has gone without an edge. When M2 sits at one level for longer than a set interval (a console reset), the watchdog cancels the count and drops the flag and the interrupt. This interrupt is not gated by any other enable, and no other status register reports it.

The register port has two addresses. Address 0 is written with the low byte and read as the flag register. Address 1 is written with the high byte and always reads zero. A read of address 0 returns zero while the timer runs. Once the timer has stopped, the same read returns the flag in bit 7 and clears the flag and the interrupt.

Top module: `oneshot_timer16`

## Requirements
- R1: After reset (the asynchronous `rst_n` or a reapplied reset in mid-count) the count and flag are zero, `irq` is 0 and address 0 reads 8'h00.
- R2: A write to address 1 (`bus_sel`=1) loads the high byte of the count. It never starts a stopped timer.
- R3: A write to address 0 (`bus_sel`=0) loads the low byte and starts the timer when the combined 16-bit value is nonzero. When the combined value is zero, the timer stops and stays stopped.
- R4: While running, the count drops by exactly one per rising edge of `m2`. Falling edges have no effect.
- R5: The step from 16'h0001 to 16'h0000 sets the flag, drives `irq` high and stops the timer. Further `m2` edges leave `irq` high.
- R6: A read of address 0 while the timer runs returns 8'h00 and leaves a previously set flag in place.
- R7: A read of address 0 while stopped returns the flag in bit 7 (8'h80 or 8'h00). It then clears the flag and `irq`, so the next read returns 8'h00.
- R8: A write to either address while running replaces that byte of the live count, and counting continues from the new value.
- R9: When `m2` holds a level, high or low, for at least GAP_NS, the timer stops, the count becomes zero, and the flag and `irq` clear.
- R10: An `m2` pause shorter than GAP_NS has no effect on the count, the flag or `irq`.
- R11: A read of address 1 returns 8'h00 and does not clear the flag or `irq`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running reference clock for all logic |
| rst_n | input | 1 | Asynchronous active-low reset |
| m2 | input | 1 | CPU bus clock, asynchronous to `clk` |
| bus_wr | input | 1 | Register write strobe, one `clk` cycle |
| bus_rd | input | 1 | Register read strobe, one `clk` cycle |
| bus_sel | input | 1 | Register address: 0 low byte / flag, 1 high byte |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| irq | output | 1 | Timer interrupt, active high |

## Verification
The bench arms the timer with 16'h0100 and counts exactly 255 edges, then one more. A design that starts on the high-byte write, or that counts both edges of M2, fires at the wrong edge. It restarts a timer while the flag is still set and then stops it with a zero low byte. This shows whether a read during the run wrongly clears the flag. The bench also rewrites each byte of a live count, so a design that only stages writes runs out the old value. Finally it holds M2 quiet for just under and then just over the gap interval, high and low. A watchdog that is too eager, or one that keeps a stale count, then leaves IRQ in the wrong state.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;
  // Register port geometry
  localparam int TMR_BYTE_W = 8;
  localparam int TMR_CNT_W  = 2 * TMR_BYTE_W;
  localparam int TMR_FLAG_BIT = 7;

  typedef enum logic {
    SEL_LOW_FLAG = 1'b0,
    SEL_HIGH     = 1'b1
  } tmr_sel_e;
endpackage

// File: rtl/tmr16_edge_sync.sv
module tmr16_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic m2_async,
  output logic m2_rise,
  output logic m2_edge
);
  // sh[STAGES-1] is the settled sample, sh[STAGES] the previous one
  logic [STAGES:0] sh_q;
  logic [STAGES:0] sh_d;

  always_comb begin
    sh_d[0] = m2_async;
    for (int i = 1; i <= STAGES; i++) sh_d[i] = sh_q[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign m2_rise = sh_q[STAGES-1] & ~sh_q[STAGES];
  assign m2_edge = sh_q[STAGES-1] ^  sh_q[STAGES];
endmodule

// File: rtl/tmr16_gap_watch.sv
module tmr16_gap_watch #(
  parameter int GAP_CYCLES = 2240
) (
  input  logic clk,
  input  logic rst_n,
  input  logic edge_seen,
  output logic gap_active
);
  localparam int GW = $clog2(GAP_CYCLES + 1);
  localparam logic [GW-1:0] LIMIT = GW'(GAP_CYCLES);

  logic [GW-1:0] quiet_q;
  logic [GW-1:0] quiet_d;
  logic          quiet_en;

  // Counter saturates at LIMIT and restarts on any M2 edge
  always_comb begin
    quiet_en = edge_seen | (quiet_q != LIMIT);
    quiet_d  = edge_seen ? '0 : quiet_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        quiet_q <= '0;
    else if (quiet_en) quiet_q <= quiet_d;
  end

  assign gap_active = (quiet_q == LIMIT);
endmodule

// File: rtl/tmr16_count_core.sv
module tmr16_count_core
  import tmr16_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  abort,
  input  logic                  wr_low,
  input  logic                  wr_high,
  input  logic [TMR_BYTE_W-1:0] wbyte,
  input  logic                  tick,
  input  logic                  clr_flag,
  output logic [TMR_CNT_W-1:0]  count,
  output logic                  running,
  output logic                  flag
);
  localparam logic [TMR_CNT_W-1:0] ONE = TMR_CNT_W'(1);

  logic [TMR_CNT_W-1:0] cnt_q, cnt_d;
  logic                 run_q, run_d;
  logic                 flg_q, flg_d;
  logic                 upd_en;

  always_comb begin
    cnt_d = cnt_q;
    run_d = run_q;
    flg_d = flg_q;
    if (abort) begin
      cnt_d = '0;
      run_d = 1'b0;
      flg_d = 1'b0;
    end else begin
      if (clr_flag) flg_d = 1'b0;
      if (wr_low) begin
        cnt_d = {cnt_q[TMR_CNT_W-1:TMR_BYTE_W], wbyte};
        run_d = (cnt_d != '0);
      end else if (wr_high) begin
        cnt_d = {wbyte, cnt_q[TMR_BYTE_W-1:0]};
        run_d = run_q & (cnt_d != '0);
      end else if (run_q && tick) begin
        cnt_d = cnt_q - ONE;
        if (cnt_q == ONE) begin
          run_d = 1'b0;
          flg_d = 1'b1;
        end
      end
    end
  end

  assign upd_en = abort | clr_flag | wr_low | wr_high | (run_q & tick);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
      flg_q <= 1'b0;
    end else if (upd_en) begin
      cnt_q <= cnt_d;
      run_q <= run_d;
      flg_q <= flg_d;
    end
  end

  assign count   = cnt_q;
  assign running = run_q;
  assign flag    = flg_q;
endmodule

// File: rtl/oneshot_timer16.sv
module oneshot_timer16
  import tmr16_pkg::*;
#(
  parameter int REF_CLK_MHZ = 200,
  parameter int GAP_NS      = 11200,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  m2,
  input  logic                  bus_wr,
  input  logic                  bus_rd,
  input  logic                  bus_sel,
  input  logic [TMR_BYTE_W-1:0] bus_wdata,
  output logic [TMR_BYTE_W-1:0] bus_rdata,
  output logic                  irq
);
  localparam int GAP_CYCLES = (REF_CLK_MHZ * GAP_NS) / 1000;

  // Reset: asserted asynchronously, released on clk
  logic [1:0] rst_sh;
  logic       rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sh <= 2'b00;
    else        rst_sh <= {rst_sh[0], 1'b1};
  end
  assign rst_q = rst_sh[1];

  logic rise_w, edge_w, gap_w;
  logic [TMR_CNT_W-1:0] cnt_w;
  logic run_w, flag_w;
  logic wr_lo, wr_hi, clr_w;

  tmr16_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_q),
    .m2_async (m2),
    .m2_rise  (rise_w),
    .m2_edge  (edge_w)
  );

  tmr16_gap_watch #(.GAP_CYCLES(GAP_CYCLES)) u_gap (
    .clk        (clk),
    .rst_n      (rst_q),
    .edge_seen  (edge_w),
    .gap_active (gap_w)
  );

  assign wr_lo = bus_wr & (tmr_sel_e'(bus_sel) == SEL_LOW_FLAG);
  assign wr_hi = bus_wr & (tmr_sel_e'(bus_sel) == SEL_HIGH);
  assign clr_w = bus_rd & (tmr_sel_e'(bus_sel) == SEL_LOW_FLAG) & ~run_w;

  tmr16_count_core u_core (
    .clk      (clk),
    .rst_n    (rst_q),
    .abort    (gap_w),
    .wr_low   (wr_lo),
    .wr_high  (wr_hi),
    .wbyte    (bus_wdata),
    .tick     (rise_w),
    .clr_flag (clr_w),
    .count    (cnt_w),
    .running  (run_w),
    .flag     (flag_w)
  );

  always_comb begin
    bus_rdata = '0;
    if (tmr_sel_e'(bus_sel) == SEL_LOW_FLAG && !run_w)
      bus_rdata[TMR_FLAG_BIT] = flag_w;
  end

  assign irq = flag_w;
endmodule

// File: rtl/tmr16_checker.sv
module tmr16_checker
  import tmr16_pkg::*;
(
  input logic                  clk,
  input logic                  rst_q,
  input logic                  bus_wr,
  input logic                  bus_rd,
  input logic                  bus_sel,
  input logic [TMR_BYTE_W-1:0] bus_wdata,
  input logic [TMR_BYTE_W-1:0] bus_rdata,
  input logic                  irq,
  input logic                  running,
  input logic [TMR_CNT_W-1:0]  count,
  input logic                  m2_rise,
  input logic                  gap
);
  p_hi_nostart_r2: assert property (@(posedge clk) disable iff (!rst_q)
    (bus_wr && bus_sel && !running && !gap) |=> !running);

  p_lo_start_r3: assert property (@(posedge clk) disable iff (!rst_q)
    (bus_wr && !bus_sel && !gap && ({count[TMR_CNT_W-1:TMR_BYTE_W], bus_wdata} != '0))
    |=> running);

  p_step_r4: assert property (@(posedge clk) disable iff (!rst_q)
    (running && m2_rise && !bus_wr && !gap && count != 16'd1)
    |=> (count == $past(count) - 16'd1));

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_q)
    (!running && !bus_wr && !gap) |=> $stable(count));

  p_expire_r5: assert property (@(posedge clk) disable iff (!rst_q)
    (running && m2_rise && !bus_wr && !gap && count == 16'd1)
    |=> (irq && !running && count == '0));

  p_run_reads_zero_r6: assert property (@(posedge clk) disable iff (!rst_q)
    running |-> (bus_sel || bus_rdata == '0));

  p_read_clear_r7: assert property (@(posedge clk) disable iff (!rst_q)
    (bus_rd && !bus_sel && !running && !gap) |=> !irq);

  p_gap_abort_r9: assert property (@(posedge clk) disable iff (!rst_q)
    gap |=> (!irq && !running && count == '0));

  p_hi_read_keep_r11: assert property (@(posedge clk) disable iff (!rst_q)
    (bus_rd && bus_sel && irq && !gap) |=> irq);
endmodule

bind oneshot_timer16 tmr16_checker u_chk (
  .clk       (clk),
  .rst_q     (rst_q),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_sel   (bus_sel),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .irq       (irq),
  .running   (run_w),
  .count     (cnt_w),
  .m2_rise   (rise_w),
  .gap       (gap_w)
);

// File: tb/sim_oneshot_timer16.sv
`timescale 1ns/1ps
module sim_oneshot_timer16;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       m2 = 1'b0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic       bus_sel = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  oneshot_timer16 u0 (
    .clk(clk), .rst_n(rst_n), .m2(m2), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_sel(bus_sel), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  localparam logic [2:0] OP_WRLO = 3'd0, OP_WRHI = 3'd1, OP_RDLO = 3'd2,
                         OP_RDHI = 3'd3, OP_PULSE = 3'd4, OP_IRQ = 3'd5,
                         OP_HOLDHI = 3'd6, OP_HOLDLO = 3'd7;
  localparam int NV = 60;
  // {req, op, arg, expected}
  localparam logic [30:0] VEC [NV] = '{
    {4'd3, OP_WRHI, 16'd0, 8'h00},      // R3 zero value does not start
    {4'd3, OP_WRLO, 16'd0, 8'h00},
    {4'd3, OP_PULSE, 16'd3, 8'h00},
    {4'd3, OP_IRQ, 16'd0, 8'h00},
    {4'd3, OP_RDLO, 16'd0, 8'h00},
    {4'd2, OP_WRHI, 16'h01, 8'h00},     // R2 high byte alone stays idle
    {4'd2, OP_PULSE, 16'd4, 8'h00},
    {4'd2, OP_IRQ, 16'd0, 8'h00},
    {4'd2, OP_RDLO, 16'd0, 8'h00},
    {4'd3, OP_WRLO, 16'h00, 8'h00},     // R3 start at 16'h0100
    {4'd6, OP_RDLO, 16'd0, 8'h00},
    {4'd4, OP_PULSE, 16'd255, 8'h00},   // R4 one step per rise
    {4'd4, OP_IRQ, 16'd0, 8'h00},
    {4'd5, OP_PULSE, 16'd1, 8'h00},
    {4'd5, OP_IRQ, 16'd0, 8'h01},       // R5 fires on 1->0
    {4'd5, OP_PULSE, 16'd3, 8'h00},
    {4'd5, OP_IRQ, 16'd0, 8'h01},
    {4'd11, OP_RDHI, 16'd0, 8'h00},     // R11 high address reads zero
    {4'd11, OP_IRQ, 16'd0, 8'h01},
    {4'd7, OP_RDLO, 16'd0, 8'h80},      // R7 flag read and clear
    {4'd7, OP_IRQ, 16'd0, 8'h00},
    {4'd7, OP_RDLO, 16'd0, 8'h00},
    {4'd8, OP_WRHI, 16'h00, 8'h00},     // R8 low byte overwrite
    {4'd8, OP_WRLO, 16'h10, 8'h00},
    {4'd8, OP_PULSE, 16'd4, 8'h00},
    {4'd8, OP_WRLO, 16'h02, 8'h00},
    {4'd8, OP_PULSE, 16'd1, 8'h00},
    {4'd8, OP_IRQ, 16'd0, 8'h00},
    {4'd8, OP_PULSE, 16'd1, 8'h00},
    {4'd8, OP_IRQ, 16'd0, 8'h01},
    {4'd6, OP_WRLO, 16'h03, 8'h00},     // R6 restart with flag set
    {4'd6, OP_RDLO, 16'd0, 8'h00},
    {4'd3, OP_WRLO, 16'h00, 8'h00},     // R3 zero low byte stops
    {4'd6, OP_IRQ, 16'd0, 8'h01},
    {4'd6, OP_RDLO, 16'd0, 8'h80},
    {4'd8, OP_WRLO, 16'h05, 8'h00},     // R8 high byte overwrite
    {4'd8, OP_PULSE, 16'd2, 8'h00},
    {4'd8, OP_WRHI, 16'h01, 8'h00},
    {4'd8, OP_PULSE, 16'd258, 8'h00},
    {4'd8, OP_IRQ, 16'd0, 8'h00},
    {4'd8, OP_PULSE, 16'd1, 8'h00},
    {4'd8, OP_IRQ, 16'd0, 8'h01},
    {4'd7, OP_RDLO, 16'd0, 8'h80},
    {4'd10, OP_WRHI, 16'h00, 8'h00},    // R10 short pause ignored
    {4'd10, OP_WRLO, 16'h03, 8'h00},
    {4'd10, OP_PULSE, 16'd1, 8'h00},
    {4'd10, OP_HOLDLO, 16'd2000, 8'h00},
    {4'd10, OP_PULSE, 16'd1, 8'h00},
    {4'd10, OP_IRQ, 16'd0, 8'h00},
    {4'd10, OP_PULSE, 16'd1, 8'h00},
    {4'd10, OP_IRQ, 16'd0, 8'h01},
    {4'd9, OP_HOLDHI, 16'd2400, 8'h00}, // R9 long high clears flag
    {4'd9, OP_IRQ, 16'd0, 8'h00},
    {4'd9, OP_RDLO, 16'd0, 8'h00},
    {4'd9, OP_WRLO, 16'h50, 8'h00},     // R9 long low aborts count
    {4'd9, OP_PULSE, 16'd2, 8'h00},
    {4'd9, OP_HOLDLO, 16'd2400, 8'h00},
    {4'd9, OP_PULSE, 16'd100, 8'h00},
    {4'd9, OP_IRQ, 16'd0, 8'h00},
    {4'd9, OP_RDLO, 16'd0, 8'h00}
  };

  task automatic check(input int req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    @(negedge clk); bus_sel = sel; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic sel, input int req, input logic [7:0] exp);
    logic [7:0] v;
    @(negedge clk); bus_sel = sel; bus_rd = 1'b1;
    #1 v = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
    check(req, v, exp);
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); m2 = 1'b1;
      repeat (6) @(negedge clk);
      m2 = 1'b0;
      repeat (6) @(negedge clk);
    end
  endtask

  task automatic chk_irq(input int req, input logic exp);
    @(negedge clk);
    check(req, {7'd0, irq}, {7'd0, exp});
  endtask

  initial begin
    #(5.0 * 190000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 state after power-up reset
    chk_irq(1, 1'b0);
    rd(1'b0, 1, 8'h00);

    for (int k = 0; k < NV; k++) begin
      int        req;
      logic [2:0] op;
      logic [15:0] arg;
      logic [7:0]  ex;
      {req, op, arg, ex} = {28'd0, VEC[k]};
      req = int'(VEC[k][30:27]);
      op  = VEC[k][26:24];
      arg = VEC[k][23:8];
      ex  = VEC[k][7:0];
      case (op)
        OP_WRLO:   wr(1'b0, arg[7:0]);
        OP_WRHI:   wr(1'b1, arg[7:0]);
        OP_RDLO:   rd(1'b0, req, ex);
        OP_RDHI:   rd(1'b1, req, ex);
        OP_PULSE:  pulses(int'(arg));
        OP_IRQ:    chk_irq(req, ex[0]);
        OP_HOLDHI: begin
          @(negedge clk); m2 = 1'b1;
          repeat (int'(arg)) @(negedge clk);
          m2 = 1'b0;
          repeat (4) @(negedge clk);
        end
        default: begin
          @(negedge clk); m2 = 1'b0;
          repeat (int'(arg)) @(negedge clk);
        end
      endcase
    end

    // R1 reset reapplied while counting with the flag set
    wr(1'b0, 8'h04);
    pulses(4);
    chk_irq(5, 1'b1);
    wr(1'b0, 8'h20);
    pulses(2);
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk_irq(1, 1'b0);
    pulses(40);
    chk_irq(1, 1'b0);
    rd(1'b0, 1, 8'h00);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule